// File: doc/BRIEF.md
# Programmable Raster Timing Generator for RGB Panels

This block drives the synchronisation side of a parallel RGB panel. From a system clock it derives a pixel-clock enable with a programmable divide ratio, or passes the clock through 1:1. On every pixel tick it steps a horizontal and a vertical phase counter. From these it produces horizontal sync, vertical sync and data-enable outputs, and each output has its own polarity inversion. Every length and the divide ratio are held as the wanted count minus one.

A video enable input starts the raster on the next pixel tick and stops it only after the current frame has finished. A frame interrupt sets a pending flag when the vertical counter enters a selected phase, normally the start of vertical sync. The flag is set only when both interrupt enables are high and is cleared by a write-one-to-clear strobe. The pixel data path is not part of this block.

Top module: `lcd_timing_gen`

## Requirements
- R1: With `div_on` high, `pix_ce` is high for one system cycle in every `div_m1`+1 cycles.
- R2: With `div_on` low, `pix_ce` is high on every system cycle, whatever the value of `div_m1`.
- R3: Each line is made of sync (`h_sync_m1`+1 ticks), back porch (`h_back_m1`+1), active (`h_act_m1`+1) and front porch (`h_front_m1`+1), in that order. `hsync` is active only during the sync part.
- R4: Each frame is made of the same four parts counted in lines (`v_*_m1`+1 each) in the same order. `vsync` becomes active on the same tick that `hsync` becomes active, and stays active for `v_sync_m1`+1 whole lines.
- R5: `de` is active only when both the horizontal and the vertical counters are in their active part, which gives (`h_act_m1`+1)×(`v_act_m1`+1) active ticks per frame.
- R6: While the raster is stopped, `hsync`, `vsync` and `de` sit at their inactive levels. Once `video_en` rises, the raster begins on the next pixel tick at the first sync tick of line 0 of a frame.
- R7: If `video_en` is cleared during a frame, the frame still runs to its last front-porch tick, and then the outputs go inactive.
- R8: Output polarity is active-high when `hs_inv`, `vs_inv` or `de_inv` is 0. Setting one of these bits to 1 inverts only its own output.
- R9: `irq_pend` is set when the vertical counter enters the phase given by `irq_sel`. The encoding is 0 for sync, 1 for back porch, 2 for active and 3 for front porch.
- R10: `irq_pend` is never set unless both `irq_en` and `irq_frame_en` are high.
- R11: A one-cycle pulse on `irq_clr` clears `irq_pend`. If a new event arrives in the same cycle, the event wins.
- R12: `irq` equals `irq_pend` gated by `irq_en`. Clearing `irq_en` does not clear `irq_pend`.
- R13: After reset, `hsync`, `vsync`, `de`, `irq_pend` and `irq` are all 0, with no inversion applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| video_en | input | 1 | Start/stop raster output |
| div_on | input | 1 | 1 = use divider, 0 = pixel clock equals system clock |
| div_m1 | input | DIV_W | Divide ratio minus one |
| h_sync_m1 | input | H_W | Horizontal sync width minus one |
| h_back_m1 | input | H_W | Horizontal back porch minus one |
| h_act_m1 | input | H_W | Active width minus one |
| h_front_m1 | input | H_W | Horizontal front porch minus one |
| v_sync_m1 | input | V_W | Vertical sync lines minus one |
| v_back_m1 | input | V_W | Vertical back porch minus one |
| v_act_m1 | input | V_W | Active height minus one |
| v_front_m1 | input | V_W | Vertical front porch minus one |
| hs_inv | input | 1 | Invert hsync |
| vs_inv | input | 1 | Invert vsync |
| de_inv | input | 1 | Invert de |
| irq_en | input | 1 | Global interrupt enable |
| irq_frame_en | input | 1 | Frame interrupt enable |
| irq_sel | input | 2 | Vertical phase that raises the frame event |
| irq_clr | input | 1 | Write-one-to-clear strobe for the pending flag |
| pix_ce | output | 1 | Pixel-clock enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| irq_pend | output | 1 | Pending frame interrupt |
| irq | output | 1 | Interrupt request |

## Verification
Some behaviours are checked by assertions on every cycle. A phase counter leaves its phase only at the end of a count. Vertical sync rises only together with horizontal sync. Data enable rises only out of the back porch. The raster starts only on a pixel tick and stops only at a frame end. The divider count stays within its range. The pending flag falls only under a clear strobe and rises only when both enables are set. Other behaviours need a running raster, so only the bench scenarios can show them: the exact part lengths, line and frame lengths, the per-frame active count, stopping after a completed frame, polarity inversion, and the phase chosen for the interrupt.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

   typedef enum logic [1:0] {
      PH_SYNC  = 2'd0,
      PH_BACK  = 2'd1,
      PH_ACT   = 2'd2,
      PH_FRONT = 2'd3
   } tg_phase_e;

   function automatic tg_phase_e tg_next_phase(input tg_phase_e ph);
      case (ph)
         PH_SYNC:  return PH_BACK;
         PH_BACK:  return PH_ACT;
         PH_ACT:   return PH_FRONT;
         default:  return PH_SYNC;
      endcase
   endfunction

endpackage

// File: rtl/lcd_tg_clkdiv.sv
module lcd_tg_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             div_on,
   input  logic [DIV_W-1:0] div_m1,
   output logic             pix_ce
);

   if (DIV_W < 1) begin : g_bad_div_w
      $error("lcd_tg_clkdiv: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] dcnt;
   logic             wrap;

   assign wrap   = (dcnt >= div_m1);
   assign pix_ce = !div_on || wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt <= '0;
      end else if (!div_on || wrap) begin
         dcnt <= '0;
      end else begin
         dcnt <= dcnt + 1'b1;
      end
   end

   // R1: the count never runs past the programmed ratio
   a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      div_on |=> (dcnt <= $past(div_m1)));

endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis
   import lcd_tg_pkg::*;
#(
   parameter int W = 12
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      reload,
   input  logic      step,
   input  logic [W-1:0] len_sync,
   input  logic [W-1:0] len_back,
   input  logic [W-1:0] len_act,
   input  logic [W-1:0] len_front,
   output tg_phase_e phase,
   output logic      last
);

   if (W < 1) begin : g_bad_w
      $error("lcd_tg_axis: W must be at least 1");
   end

   logic [W-1:0] cnt;
   logic [W-1:0] next_len;
   tg_phase_e    nph;

   assign nph  = tg_next_phase(phase);
   assign last = (phase == PH_FRONT) && (cnt == '0);

   always_comb begin
      case (nph)
         PH_SYNC:  next_len = len_sync;
         PH_BACK:  next_len = len_back;
         PH_ACT:   next_len = len_act;
         default:  next_len = len_front;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_SYNC;
         cnt   <= '0;
      end else if (reload) begin
         phase <= PH_SYNC;
         cnt   <= len_sync;
      end else if (step) begin
         if (cnt == '0) begin
            phase <= nph;
            cnt   <= next_len;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   // R3/R4: a phase is left only when its count has run out
   a_r3_r4_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && !(step && cnt == '0)) |=> (phase == $past(phase)));

endmodule

// File: rtl/lcd_tg_irq.sv
module lcd_tg_irq
   import lcd_tg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      running,
   input  tg_phase_e vphase,
   input  logic [1:0] sel,
   input  logic      irq_en,
   input  logic      frame_en,
   input  logic      clr,
   output logic      pend,
   output logic      irq
);

   logic      run_prev;
   tg_phase_e ph_prev;
   logic      entered;
   logic      event_hit;

   assign entered   = running && (!run_prev || (vphase != ph_prev));
   assign event_hit = entered && (vphase == tg_phase_e'(sel)) && irq_en && frame_en;
   assign irq       = pend && irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_prev <= 1'b0;
         ph_prev  <= PH_SYNC;
         pend     <= 1'b0;
      end else begin
         run_prev <= running;
         ph_prev  <= vphase;
         if (event_hit) begin
            pend <= 1'b1;
         end else if (clr) begin
            pend <= 1'b0;
         end
      end
   end

   // R11: the pending flag only drops under a clear strobe
   a_r11_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend) |-> $past(clr));

   // R10: the pending flag only rises with both enables set
   a_r10_rise_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(irq_en && frame_en));

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
   import lcd_tg_pkg::*;
#(
   parameter int H_W     = 12,
   parameter int V_W     = 11,
   parameter int DIV_W   = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             video_en,
   input  logic             div_on,
   input  logic [DIV_W-1:0] div_m1,
   input  logic [H_W-1:0]   h_sync_m1,
   input  logic [H_W-1:0]   h_back_m1,
   input  logic [H_W-1:0]   h_act_m1,
   input  logic [H_W-1:0]   h_front_m1,
   input  logic [V_W-1:0]   v_sync_m1,
   input  logic [V_W-1:0]   v_back_m1,
   input  logic [V_W-1:0]   v_act_m1,
   input  logic [V_W-1:0]   v_front_m1,
   input  logic             hs_inv,
   input  logic             vs_inv,
   input  logic             de_inv,
   input  logic             irq_en,
   input  logic             irq_frame_en,
   input  logic [1:0]       irq_sel,
   input  logic             irq_clr,
   output logic             pix_ce,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic             irq_pend,
   output logic             irq
);

   if (H_W < 2 || V_W < 2) begin : g_bad_geom
      $error("lcd_timing_gen: H_W and V_W must be at least 2");
   end

   logic      tick;
   logic      running;
   tg_phase_e hph, vph;
   logic      h_last, v_last;
   logic      frame_last;
   logic      hs_act, vs_act, de_act;

   lcd_tg_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .div_on (div_on),
      .div_m1 (div_m1),
      .pix_ce (tick)
   );

   lcd_tg_axis #(.W(H_W)) u_hax (
      .clk       (clk),
      .rst_n     (rst_n),
      .reload    (!running),
      .step      (tick && running),
      .len_sync  (h_sync_m1),
      .len_back  (h_back_m1),
      .len_act   (h_act_m1),
      .len_front (h_front_m1),
      .phase     (hph),
      .last      (h_last)
   );

   lcd_tg_axis #(.W(V_W)) u_vax (
      .clk       (clk),
      .rst_n     (rst_n),
      .reload    (!running),
      .step      (tick && running && h_last),
      .len_sync  (v_sync_m1),
      .len_back  (v_back_m1),
      .len_act   (v_act_m1),
      .len_front (v_front_m1),
      .phase     (vph),
      .last      (v_last)
   );

   assign frame_last = h_last && v_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
      end else if (tick) begin
         if (!running) begin
            running <= video_en;
         end else if (frame_last && !video_en) begin
            running <= 1'b0;
         end
      end
   end

   assign hs_act = running && (hph == PH_SYNC);
   assign vs_act = running && (vph == PH_SYNC);
   assign de_act = running && (hph == PH_ACT) && (vph == PH_ACT);

   if (OUT_REG) begin : g_out_reg
      logic hs_q, vs_q, de_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
            de_q <= 1'b0;
         end else begin
            hs_q <= hs_act ^ hs_inv;
            vs_q <= vs_act ^ vs_inv;
            de_q <= de_act ^ de_inv;
         end
      end
      assign hsync = hs_q;
      assign vsync = vs_q;
      assign de    = de_q;
   end else begin : g_out_comb
      assign hsync = hs_act ^ hs_inv;
      assign vsync = vs_act ^ vs_inv;
      assign de    = de_act ^ de_inv;
   end

   assign pix_ce = tick;

   lcd_tg_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .running  (running),
      .vphase   (vph),
      .sel      (irq_sel),
      .irq_en   (irq_en),
      .frame_en (irq_frame_en),
      .clr      (irq_clr),
      .pend     (irq_pend),
      .irq      (irq)
   );

   // R6: the raster only starts on a pixel tick with video enabled
   a_r6_start_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> $past(tick && video_en));

   // R7: the raster only stops at the last tick of a frame
   a_r7_stop_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> $past(tick && frame_last && !video_en));

   // R4: vertical sync starts together with horizontal sync
   a_r4_vs_with_hs: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vs_act) |-> $rose(hs_act));

   // R3: the active part always follows the back porch
   a_r3_de_after_back: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(de_act) |-> ($past(hph) == PH_BACK));

endmodule

// File: tb/lcd_timing_gen_test.sv
`timescale 1ns/1ps
module lcd_timing_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        video_en = 1'b0;
   logic        div_on = 1'b1;
   logic [7:0]  div_m1 = 8'd1;
   logic [11:0] h_sync_m1 = 12'd1, h_back_m1 = 12'd1, h_act_m1 = 12'd3, h_front_m1 = 12'd0;
   logic [10:0] v_sync_m1 = 11'd0, v_back_m1 = 11'd1, v_act_m1 = 11'd2, v_front_m1 = 11'd0;
   logic        hs_inv = 1'b0, vs_inv = 1'b0, de_inv = 1'b0;
   logic        irq_en = 1'b0, irq_frame_en = 1'b0;
   logic [1:0]  irq_sel = 2'd0;
   logic        irq_clr = 1'b0;
   logic        pix_ce, hsync, vsync, de, irq_pend, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // line = 2+2+4+1 = 9 ticks, frame = 1+2+3+1 = 7 lines = 63 ticks
   localparam int LINE_T  = 9;
   localparam int FRAME_T = 63;
   localparam int DE_PER_FRAME = 12;

   always #2.5 clk = ~clk;

   lcd_timing_gen uut (
      .clk(clk), .rst_n(rst_n), .video_en(video_en), .div_on(div_on), .div_m1(div_m1),
      .h_sync_m1(h_sync_m1), .h_back_m1(h_back_m1), .h_act_m1(h_act_m1), .h_front_m1(h_front_m1),
      .v_sync_m1(v_sync_m1), .v_back_m1(v_back_m1), .v_act_m1(v_act_m1), .v_front_m1(v_front_m1),
      .hs_inv(hs_inv), .vs_inv(vs_inv), .de_inv(de_inv),
      .irq_en(irq_en), .irq_frame_en(irq_frame_en), .irq_sel(irq_sel), .irq_clr(irq_clr),
      .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de), .irq_pend(irq_pend), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      do @(negedge clk); while (!pix_ce);
   endtask

   task automatic wait_vs_rise();
      bit prev;
      prev = vsync;
      forever begin
         tick();
         if (!prev && vsync) break;
         prev = vsync;
      end
   endtask

   task automatic pulse_clear();
      @(negedge clk) irq_clr = 1'b1;
      @(negedge clk) irq_clr = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk({hsync, vsync, de, irq_pend, irq} == 5'b0, "R13 reset outputs", {hsync, vsync, de, irq_pend, irq}, 0);
      repeat (30) @(negedge clk);
      chk({hsync, vsync, de} == 3'b0, "R6 idle outputs inactive", {hsync, vsync, de}, 0);
   endtask

   task automatic measure_period(output int n);
      tick(); tick();
      n = 0;
      do begin @(negedge clk); n++; end while (!pix_ce);
   endtask

   task automatic t_divider();
      int n;
      int ones;
      div_m1 = 8'd3;
      measure_period(n);
      chk(n == 4, "R1 divide by 4", n, 4);
      div_m1 = 8'd1;
      measure_period(n);
      chk(n == 2, "R1 divide by 2", n, 2);
      div_on = 1'b0; div_m1 = 8'd5;
      ones = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (pix_ce) ones++; end
      chk(ones == 10, "R2 bypass every cycle", ones, 10);
      div_on = 1'b1; div_m1 = 8'd1;
      tick(); tick();
   endtask

   task automatic t_start();
      tick();
      video_en = 1'b1;
      tick();
      chk(hsync && vsync && !de, "R6 first tick is sync of line 0", {hsync, vsync, de}, 3'b110);
      tick();
      chk(hsync == 1'b1, "R3 hsync second tick", hsync, 1);
      tick();
      chk(hsync == 1'b0, "R3 hsync ends after 2 ticks", hsync, 0);
      for (int i = 3; i < LINE_T; i++) tick();
      tick();
      chk(hsync && !vsync, "R4 line 9 ticks and vsync one line", {hsync, vsync}, 2'b10);
   endtask

   task automatic t_line_pattern();
      logic [LINE_T-1:0] hs_b, de_b;
      do tick(); while (!de);
      do tick(); while (!hsync);
      for (int i = 0; i < LINE_T; i++) begin
         hs_b[i] = hsync; de_b[i] = de;
         tick();
      end
      chk(hs_b == 9'b000000011, "R3 hsync placement in line", hs_b, 9'b000000011);
      chk(de_b == 9'b011110000, "R3 R5 de after back porch", de_b, 9'b011110000);
      chk(hsync == 1'b1, "R3 next line starts", hsync, 1);
   endtask

   task automatic t_frame();
      int vs_n, de_n;
      wait_vs_rise();
      chk(hsync == 1'b1, "R4 vsync rises with hsync", hsync, 1);
      vs_n = 0; de_n = 0;
      for (int i = 0; i < FRAME_T; i++) begin
         if (vsync) vs_n++;
         if (de) de_n++;
         tick();
      end
      chk(vs_n == LINE_T, "R4 vsync one line long", vs_n, LINE_T);
      chk(de_n == DE_PER_FRAME, "R5 active ticks per frame", de_n, DE_PER_FRAME);
      chk(vsync == 1'b1, "R4 frame length 63 ticks", vsync, 1);
   endtask

   task automatic t_stop();
      int de_n;
      wait_vs_rise();
      video_en = 1'b0;
      de_n = 0;
      for (int i = 0; i < 100; i++) begin
         if (de) de_n++;
         tick();
      end
      chk(de_n == DE_PER_FRAME, "R7 frame completes after disable", de_n, DE_PER_FRAME);
      chk({hsync, vsync, de} == 3'b0, "R7 idle after frame end", {hsync, vsync, de}, 0);
   endtask

   task automatic t_polarity();
      hs_inv = 1'b1; vs_inv = 1'b1; de_inv = 1'b1;
      @(negedge clk);
      chk({hsync, vsync, de} == 3'b111, "R8 inverted idle levels", {hsync, vsync, de}, 3'b111);
      hs_inv = 1'b0; de_inv = 1'b0;
      @(negedge clk);
      chk({hsync, vsync, de} == 3'b010, "R8 inversion is per output", {hsync, vsync, de}, 3'b010);
      vs_inv = 1'b0;
      tick();
      video_en = 1'b1;
      tick();
   endtask

   task automatic t_irq_sync();
      bit prev;
      irq_sel = 2'd0; irq_en = 1'b1; irq_frame_en = 1'b1;
      do tick(); while (!de);
      pulse_clear();
      chk(irq_pend == 1'b0, "R11 clear strobe", irq_pend, 0);
      prev = irq_pend;
      forever begin
         bit pv;
         pv = vsync;
         prev = irq_pend;
         tick();
         if (!pv && vsync) break;
      end
      chk(prev == 1'b0 && irq_pend == 1'b1, "R9 pending at vsync start", {prev, irq_pend}, 2'b01);
      chk(irq == 1'b1, "R12 irq follows pending", irq, 1);
      irq_en = 1'b0;
      @(negedge clk);
      chk(irq == 1'b0 && irq_pend == 1'b1, "R12 irq gated, pending kept", {irq, irq_pend}, 2'b01);
   endtask

   task automatic t_irq_active();
      irq_en = 1'b1; irq_sel = 2'd2;
      wait_vs_rise();
      pulse_clear();
      do tick(); while (vsync);
      chk(irq_pend == 1'b0, "R9 select active: none at back porch", irq_pend, 0);
      do tick(); while (!de);
      chk(irq_pend == 1'b1, "R9 select active: set at active start", irq_pend, 1);
   endtask

   task automatic t_irq_off();
      int seen;
      irq_sel = 2'd0; irq_en = 1'b1; irq_frame_en = 1'b0;
      pulse_clear();
      seen = 0;
      for (int i = 0; i < 70; i++) begin tick(); if (irq_pend) seen++; end
      chk(seen == 0, "R10 frame enable clear", seen, 0);
      irq_en = 1'b0; irq_frame_en = 1'b1;
      seen = 0;
      for (int i = 0; i < 70; i++) begin tick(); if (irq_pend) seen++; end
      chk(seen == 0, "R10 global enable clear", seen, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_divider();
      t_start();
      t_line_pattern();
      t_frame();
      t_stop();
      t_polarity();
      t_irq_sync();
      t_irq_active();
      t_irq_off();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule